// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Backoff Controller

This block decides when a half-duplex Ethernet MAC transmitter may launch a frame, when a collided frame may try again, and when a frame must be given up. The host signals that a frame is queued; the controller waits for the medium to go quiet, grants a start, and then watches for a collision or the serialiser's end-of-frame marker. After a collision it draws a random number of slot times (truncated binary exponential backoff) and counts them down on the bit-time tick before deferring to carrier again and re-granting the same frame.

Configuration selects a one-shot mode with no retries, the width of the random backoff range, and an optional watchdog that abandons a frame that has waited too long for the medium. In full-duplex mode carrier and collision are ignored and every ready frame is granted at once. Status outputs are single-cycle registered pulses that accompany the frame-done pulse of the frame they describe.

Top module: `hd_tx_arbiter`

## Requirements
- R1: Out of reset every output is low, and no start is granted unless a frame is ready.
- R2: In half-duplex mode a start pulse (`tx_start`, one cycle) is granted only while carrier sense is low; with carrier low it appears on the clock edge after a ready frame is seen, and while carrier stays high none appears.
- R3: In full-duplex mode a ready frame is granted regardless of carrier sense, and a collision during the frame is ignored (no abort, no backoff).
- R4: `tx_last` during a granted frame ends it with a one-cycle `frame_done` pulse and no abort or error status.
- R5: With `cfg_no_retry` high, a collision ends the frame at once: `frame_done`, `frame_abort` and `excess_coll` pulse together and no further start is granted for it.
- R6: With `cfg_no_retry` low, after the n-th collision the frame is granted again after a delay of S*SLOT_BITS bit ticks plus two clock cycles, where S is below 2 to the power min(n, k).
- R7: `cfg_backoff_lim` sets k: 0 selects 10 random bits, 1 selects 8, 2 selects 4 and 3 selects 1.
- R8: A frame is attempted at most MAX_ATTEMPTS (16) times; the collision of the last attempt raises `frame_abort`, `excess_coll` and `frame_done` together.
- R9: With `cfg_defer_chk` high, a frame kept waiting by carrier for more than DEFER_LIMIT bit ticks is dropped with `defer_timeout`, `frame_abort` and `frame_done` pulsing together.
- R10: With `cfg_defer_chk` low, a frame waits for the medium indefinitely and starts once carrier drops.
- R11: With `tx_enable` low, no new frame is granted; clearing it during a frame does not stop that frame's retries or its completion.
- R12: Deferral and backoff timers advance only on cycles with `bit_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1: full duplex, bypass deferral and backoff |
| tx_enable | input | 1 | Permits new frames to start |
| cfg_no_retry | input | 1 | 1: one attempt per frame |
| cfg_backoff_lim | input | 2 | Backoff random-bit selection (see R7) |
| cfg_defer_chk | input | 1 | 1: enable deferral watchdog |
| frame_ready | input | 1 | A frame is queued for transmission |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected during transmission |
| tx_last | input | 1 | Serialiser finished the current frame |
| bit_tick | input | 1 | One pulse per bit time |
| tx_start | output | 1 | Start grant pulse |
| frame_done | output | 1 | Frame finished (any outcome) pulse |
| frame_abort | output | 1 | Frame dropped pulse |
| excess_coll | output | 1 | Collision limit or single-attempt collision pulse |
| defer_timeout | output | 1 | Deferral watchdog expiry pulse |

## Verification
The bench chases the off-by-one edges: a watchdog that fires at exactly DEFER_LIMIT ticks or one tick late, a retry loop that stops at 15 or 17 attempts, and a backoff mask that ignores the selected bit count would each show up as a timeout cycle outside its narrow window, a wrong start count, or a retry gap longer than the range allows. It also holds carrier high with the watchdog off and with `tx_enable` low, where a faulty gate would leak a start, and slows the bit tick so that a timer counting clocks instead of ticks expires four times too early. Randomised frames with random carrier busy periods and collision counts cover the interaction of deferral after backoff with re-granting.

// File: rtl/txa_pkg.sv
package txa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XMIT    = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_RETRY   = 2'd3
  } txa_state_t;

  // Number of random bits permitted by the backoff-limit setting.
  function automatic int unsigned lim_to_bits(input logic [1:0] lim);
    case (lim)
      2'd0:    return 10;
      2'd1:    return 8;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/txa_lfsr.sv
module txa_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)          sreg <= SEED;
    else if (sreg[0]) sreg <= (sreg >> 1) ^ TAPS;
    else              sreg <= sreg >> 1;
  end

  assign value = sreg;

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    sreg != '0);
endmodule

// File: rtl/txa_defer_timer.sv
module txa_defer_timer #(
  parameter int LIMIT = 24288
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 2);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                      cnt <= '0;
    else if (step && cnt <= CW'(LIMIT))    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt > CW'(LIMIT));

  // R12
  defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(cnt));
  // R9
  defer_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(step));
endmodule

// File: rtl/txa_backoff.sv
module txa_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int RAND_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RAND_W-1:0] slots,
  input  logic              tick,
  output logic              zero
);
  localparam int SW = $clog2(SLOT_BITS + 1);
  localparam int RW = RAND_W + SW;
  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                        remain <= '0;
    else if (load)                  remain <= RW'(slots) * RW'(SLOT_BITS);
    else if (tick && remain != '0)  remain <= remain - 1'b1;
  end

  assign zero = (remain == '0);

  // R12
  backoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(remain));
endmodule

// File: rtl/hd_tx_arbiter.sv
module hd_tx_arbiter
  import txa_pkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int DEFER_LIMIT  = 24288,
  parameter int MAX_ATTEMPTS = 16,
  parameter int RAND_W       = 10,
  parameter int LFSR_W       = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       full_duplex,
  input  logic       tx_enable,
  input  logic       cfg_no_retry,
  input  logic [1:0] cfg_backoff_lim,
  input  logic       cfg_defer_chk,
  input  logic       frame_ready,
  input  logic       carrier_sense,
  input  logic       collision,
  input  logic       tx_last,
  input  logic       bit_tick,
  output logic       tx_start,
  output logic       frame_done,
  output logic       frame_abort,
  output logic       excess_coll,
  output logic       defer_timeout
);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);

  txa_state_t st, st_n;
  logic [AW-1:0] attempts, attempts_n;
  logic [LFSR_W-1:0] rnd;
  logic dt_expired, dt_clear, dt_step;
  logic bk_zero, bk_load;
  logic [RAND_W-1:0] bk_slots;
  logic blocked, waiting_first;
  logic start_n, done_n, abort_n, excess_n, tmo_n;

  txa_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .value(rnd)
  );

  txa_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk(clk), .rst(rst), .clear(dt_clear), .step(dt_step),
    .expired(dt_expired)
  );

  txa_backoff #(.SLOT_BITS(SLOT_BITS), .RAND_W(RAND_W)) u_backoff (
    .clk(clk), .rst(rst), .load(bk_load), .slots(bk_slots),
    .tick(bit_tick), .zero(bk_zero)
  );

  assign blocked       = carrier_sense && !full_duplex;
  assign waiting_first = (st == ST_IDLE) && frame_ready && tx_enable;
  assign dt_step       = bit_tick && blocked &&
                         (waiting_first || st == ST_RETRY);

  // Random slot count limited to min(collision number, selected bits).
  always_comb begin
    int unsigned kb;
    int unsigned ncol;
    logic [RAND_W-1:0] mask;
    ncol = int'(attempts) + 1;
    kb   = lim_to_bits(cfg_backoff_lim);
    if (kb > RAND_W) kb = RAND_W;
    if (ncol < kb)   kb = ncol;
    mask     = RAND_W'((32'd1 << kb) - 32'd1);
    bk_slots = rnd[RAND_W-1:0] & mask;
  end

  always_comb begin
    st_n       = st;
    attempts_n = attempts;
    start_n    = 1'b0;
    done_n     = 1'b0;
    abort_n    = 1'b0;
    excess_n   = 1'b0;
    tmo_n      = 1'b0;
    dt_clear   = 1'b0;
    bk_load    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!waiting_first) begin
          dt_clear = 1'b1;
        end else if (cfg_defer_chk && dt_expired) begin
          done_n = 1'b1; abort_n = 1'b1; tmo_n = 1'b1;
          dt_clear = 1'b1; attempts_n = '0; st_n = ST_IDLE;
        end else if (!blocked) begin
          start_n = 1'b1; dt_clear = 1'b1; st_n = ST_XMIT;
        end
      end
      ST_RETRY: begin
        if (cfg_defer_chk && dt_expired) begin
          done_n = 1'b1; abort_n = 1'b1; tmo_n = 1'b1;
          dt_clear = 1'b1; attempts_n = '0; st_n = ST_IDLE;
        end else if (!blocked) begin
          start_n = 1'b1; dt_clear = 1'b1; st_n = ST_XMIT;
        end
      end
      ST_XMIT: begin
        if (collision && !full_duplex) begin
          dt_clear = 1'b1;
          if (cfg_no_retry || (int'(attempts) + 1 >= MAX_ATTEMPTS)) begin
            done_n = 1'b1; abort_n = 1'b1; excess_n = 1'b1;
            attempts_n = '0; st_n = ST_IDLE;
          end else begin
            attempts_n = attempts + 1'b1;
            bk_load    = 1'b1;
            st_n       = ST_BACKOFF;
          end
        end else if (tx_last) begin
          done_n = 1'b1; attempts_n = '0; st_n = ST_IDLE;
        end
      end
      default: begin
        dt_clear = 1'b1;
        if (bk_zero) st_n = ST_RETRY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      attempts      <= '0;
      tx_start      <= 1'b0;
      frame_done    <= 1'b0;
      frame_abort   <= 1'b0;
      excess_coll   <= 1'b0;
      defer_timeout <= 1'b0;
    end else begin
      st            <= st_n;
      attempts      <= attempts_n;
      tx_start      <= start_n;
      frame_done    <= done_n;
      frame_abort   <= abort_n;
      excess_coll   <= excess_n;
      defer_timeout <= tmo_n;
    end
  end

  // R5
  excess_abort_chk: assert property (@(posedge clk) disable iff (rst)
    excess_coll |-> (frame_abort && frame_done));
  // R9
  timeout_abort_chk: assert property (@(posedge clk) disable iff (rst)
    defer_timeout |-> (frame_abort && frame_done && !excess_coll));
  // R2
  grant_medium_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(full_duplex || !carrier_sense));
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R11
  grant_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && $past(st == ST_IDLE)) |-> $past(tx_enable && frame_ready));
  // R8
  attempts_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(attempts) < MAX_ATTEMPTS);
endmodule

// File: tb/tb_hd_tx_arbiter.sv
module tb_hd_tx_arbiter;
  localparam int SLOT = 8;
  localparam int DLIM = 40;
  localparam int MAXA = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic full_duplex = 0, tx_enable = 1, cfg_no_retry = 0, cfg_defer_chk = 0;
  logic [1:0] cfg_backoff_lim = 2'd0;
  logic frame_ready = 0, carrier_sense = 0, collision = 0, tx_last = 0;
  logic bit_tick = 1;
  logic tx_start, frame_done, frame_abort, excess_coll, defer_timeout;

  int checks = 0, fails = 0;
  int tick_div = 1, tc = 0;

  hd_tx_arbiter #(.SLOT_BITS(SLOT), .DEFER_LIMIT(DLIM), .MAX_ATTEMPTS(MAXA)) dut (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .tx_enable(tx_enable),
    .cfg_no_retry(cfg_no_retry), .cfg_backoff_lim(cfg_backoff_lim),
    .cfg_defer_chk(cfg_defer_chk), .frame_ready(frame_ready),
    .carrier_sense(carrier_sense), .collision(collision), .tx_last(tx_last),
    .bit_tick(bit_tick), .tx_start(tx_start), .frame_done(frame_done),
    .frame_abort(frame_abort), .excess_coll(excess_coll),
    .defer_timeout(defer_timeout));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tc + 1 >= tick_div) begin tc = 0; bit_tick = 1'b1; end
    else begin tc++; bit_tick = 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sel_bits(input logic [1:0] lim);
    case (lim) 2'd0: return 10; 2'd1: return 8; 2'd2: return 4; default: return 1; endcase
  endfunction

  function automatic int max_gap(input int n, input logic [1:0] lim);
    int k = sel_bits(lim);
    if (n < k) k = n;
    return ((1 << k) - 1) * SLOT + 2;
  endfunction

  // sel: 0 tx_start, 1 frame_done, 2 defer_timeout. n = edges waited.
  task automatic wait_evt(input int sel, input int maxc, output int n);
    bit hit = 0;
    n = 0;
    while (!hit && n < maxc) begin
      @(negedge clk); n++;
      hit = (sel == 0) ? tx_start : (sel == 1) ? frame_done : defer_timeout;
    end
    if (!hit) n = -1;
  endtask

  task automatic pulse_coll();
    collision = 1; @(negedge clk); collision = 0;
  endtask

  // Frame with ncoll collisions then tx_last; counts starts.
  task automatic retry_frame(input logic [1:0] lim, input int ncoll,
                             input string req, output int starts);
    int n;
    starts = 0;
    cfg_backoff_lim = lim;
    frame_ready = 1;
    wait_evt(0, 50, n);
    chk(n > 0, req, "first start", n, 1);
    if (n > 0) starts++;
    for (int c = 1; c <= ncoll; c++) begin
      pulse_coll();
      if (c >= MAXA) begin
        chk(frame_done && frame_abort && excess_coll, "R8", "limit abort",
            frame_abort, 1);
        frame_ready = 0;
        return;
      end
      wait_evt(0, max_gap(c, lim) + 2, n);
      chk(n >= 2 && n <= max_gap(c, lim), req, "backoff gap", n, max_gap(c, lim));
      if (n > 0) starts++;
      else begin frame_ready = 0; return; end
    end
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk(frame_done && !frame_abort && !excess_coll, "R4", "done after last",
        frame_done, 1);
    frame_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, st;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_start && !frame_done && !frame_abort && !excess_coll && !defer_timeout,
        "R1", "reset outputs", tx_start, 0);
    rst = 0;
    repeat (5) @(negedge clk);
    chk(!tx_start, "R1", "no start without frame", tx_start, 0);

    // R2 immediate grant with idle carrier
    frame_ready = 1;
    @(negedge clk);
    chk(tx_start, "R2", "grant next edge", tx_start, 1);
    @(negedge clk);
    chk(!tx_start, "R2", "grant is one cycle", tx_start, 0);
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk(frame_done && !frame_abort, "R4", "clean completion", frame_done, 1);
    frame_ready = 0; @(negedge clk);

    // R2 carrier blocks, R10 no watchdog
    carrier_sense = 1; frame_ready = 1;
    wait_evt(0, 3 * DLIM, n);
    chk(n == -1, "R2", "no start under carrier", n, -1);
    chk(!defer_timeout && !frame_done, "R10", "waits indefinitely", defer_timeout, 0);
    carrier_sense = 0;
    wait_evt(0, 5, n);
    chk(n == 1, "R10", "start after carrier drops", n, 1);
    tx_last = 1; @(negedge clk); tx_last = 0; frame_ready = 0; @(negedge clk);

    // R9 watchdog at fast tick
    cfg_defer_chk = 1; carrier_sense = 1; frame_ready = 1;
    wait_evt(2, 4 * DLIM, n);
    chk(n >= DLIM + 1 && n <= DLIM + 3, "R9", "timeout cycle", n, DLIM + 2);
    chk(frame_abort && frame_done, "R9", "timeout aborts", frame_abort, 1);
    frame_ready = 0; @(negedge clk);
    // R12 watchdog on slow tick
    tick_div = 4; frame_ready = 1;
    wait_evt(2, 8 * DLIM, n);
    chk(n >= 4 * (DLIM + 1) - 3 && n <= 4 * (DLIM + 1) + 5, "R12",
        "timeout counts ticks", n, 4 * (DLIM + 1));
    frame_ready = 0; tick_div = 1; carrier_sense = 0; cfg_defer_chk = 0;
    repeat (2) @(negedge clk);

    // R3 full duplex
    full_duplex = 1; carrier_sense = 1; frame_ready = 1;
    wait_evt(0, 5, n);
    chk(n == 1, "R3", "grant despite carrier", n, 1);
    pulse_coll();
    chk(!frame_done && !frame_abort, "R3", "collision ignored", frame_abort, 0);
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk(frame_done && !frame_abort, "R3", "completes", frame_done, 1);
    frame_ready = 0; full_duplex = 0; carrier_sense = 0; @(negedge clk);

    // R5 single attempt
    cfg_no_retry = 1; frame_ready = 1;
    wait_evt(0, 5, n);
    pulse_coll();
    chk(frame_done && frame_abort && excess_coll, "R5", "one-shot abort",
        excess_coll, 1);
    frame_ready = 0;
    wait_evt(0, 4 * SLOT, n);
    chk(n == -1, "R5", "no retry start", n, -1);
    cfg_no_retry = 0;

    // R11 enable gating
    tx_enable = 0; frame_ready = 1;
    wait_evt(0, 20, n);
    chk(n == -1, "R11", "no start when disabled", n, -1);
    tx_enable = 1;
    wait_evt(0, 5, n);
    chk(n == 1, "R11", "start when enabled", n, 1);
    tx_enable = 0; cfg_backoff_lim = 2'd3;
    pulse_coll();
    wait_evt(0, max_gap(1, 2'd3) + 2, n);
    chk(n > 0, "R11", "retry continues while disabled", n, 2);
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk(frame_done, "R11", "frame finishes while disabled", frame_done, 1);
    frame_ready = 0; tx_enable = 1; @(negedge clk);

    // R7 / R8 limit runs
    retry_frame(2'd3, MAXA, "R7", st);
    chk(st == MAXA, "R8", "attempt count", st, MAXA);
    @(negedge clk);
    retry_frame(2'd2, MAXA, "R7", st);
    chk(st == MAXA, "R8", "attempt count lim4", st, MAXA);
    @(negedge clk);
    retry_frame(2'd1, 5, "R6", st);
    chk(st == 6, "R6", "starts with 5 collisions", st, 6);

    // Random frames: R2 R6
    for (int i = 0; i < 40; i++) begin
      int busy = $urandom % 12;
      int nc   = $urandom % 5;
      logic [1:0] lim = 2'($urandom % 4);
      if (busy > 0) begin
        carrier_sense = 1; frame_ready = 1;
        repeat (busy) begin
          @(negedge clk);
          chk(!tx_start, "R2", "random busy no start", tx_start, 0);
        end
        carrier_sense = 0;
      end
      retry_frame(lim, nc, "R6", st);
      chk(st == nc + 1, "R6", "random start count", st, nc + 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule